// File: doc/BRIEF.md
# Audio Clock Output Selector and Divider

This block makes the clocks that an audio processor drives out of the chip. A system clock tap, running in the processing clock domain, either holds its output low or passes the processing clock through divided by 1, 2 or 4. A bit clock generator, running from an audio master clock, makes the serial bit clock and the word-select (frame) signal for the output ports.

In master mode the master clock is taken to run at 256 or 384 times the sample rate. It is divided by 4 or 6 to give a 64fs bit clock with a 50% duty cycle. A word select at fs changes level every 32 bit clocks, on a falling edge of the bit clock. In slave mode the generated clock is bypassed: the bit clock output follows either the serial input clock or an external clock, and word select is held low. The bit clock is always driven identically onto a second bit-clock output.

New settings are taken in only at the terminal count of the divider that uses them. A change in the middle of a period therefore never shortens a pulse.

Top module: `audio_clk_sel`

## Requirements
- R1: With the active system clock mode at code 0 (off), or at any code above 3, `sys_clk_o` is held low.
- R2: With the active system clock mode at code 1, `sys_clk_o` follows `proc_clk`, high while `proc_clk` is high and low while it is low.
- R3: With mode code 2, `sys_clk_o` has a period of 2 `proc_clk` cycles with 1 cycle high. With mode code 3, the period is 4 cycles with 2 cycles high.
- R4: A new `sys_mode_i` value is taken in only on the clock edge where the 2-bit system divider counter wraps from 3 to 0. The output keeps the old mode until that edge.
- R5: In master mode with `ratio384_i` = 0, `bclk_o` has a period of 4 `mclk` cycles with 2 cycles high.
- R6: In master mode with `ratio384_i` = 1, `bclk_o` has a period of 6 `mclk` cycles with 3 cycles high.
- R7: In master mode, `ws_o` has a period of 64 bit clocks and spends 32 bit clocks at each level. It changes only on an edge where `bclk_o` falls. In slave mode `ws_o` is low.
- R8: In slave mode, `bclk_o` follows `ser_bclk_i` when `slv_src_i` = 0 and `ext_bclk_i` when `slv_src_i` = 1.
- R9: `bclk2_o` equals `bclk_o` at all times, in every mode.
- R10: `master_i`, `ratio384_i` and `slv_src_i` are taken in only at the end of a bit-clock period (the `mclk` edge where the generated bit clock falls). The bit-clock period in progress completes at its old length.
- R11: After reset all outputs are low and every divider starts from zero. The system clock stays off for the first 4 `proc_clk` cycles. The bit clock side starts as master with the 256fs ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| proc_clk | input | 1 | Processing clock |
| proc_rst_n | input | 1 | Active-low reset, processing clock domain |
| mclk | input | 1 | Audio master clock (256fs or 384fs) |
| mclk_rst_n | input | 1 | Active-low reset, master clock domain |
| sys_mode_i | input | 2 | System clock mode: 0 off, 1 div1, 2 div2, 3 div4 |
| master_i | input | 1 | 1 selects master mode, 0 slave mode |
| ratio384_i | input | 1 | 1 selects a 384fs master clock, 0 a 256fs one |
| slv_src_i | input | 1 | Slave source: 0 serial input clock, 1 external clock |
| ser_bclk_i | input | 1 | Serial input bit clock |
| ext_bclk_i | input | 1 | External bit clock |
| sys_clk_o | output | 1 | System clock output |
| bclk_o | output | 1 | Primary output bit clock |
| bclk2_o | output | 1 | Secondary output bit clock, copy of the primary |
| ws_o | output | 1 | Word select at fs (master mode) |

## Verification
The assertions check several rules on every cycle. The off mode must hold the system output low, and divide-by-2 must toggle it each cycle. Both active configuration registers may change only one cycle after their divider's terminal count. Word select may move only on a bit-clock falling edge, and no master high phase may last longer than three master clock cycles. The period and duty cycle in each mode, the exact cycle when a mid-period change takes effect, and the slave bypass with its mirrored output are only visible through the bench's scenarios. There the bench measures edges and compares the outputs with the clocks it drives itself.

// File: rtl/aclk_pkg.sv
`timescale 1ns/1ps
package aclk_pkg;
   typedef struct packed {
      logic master;   // 1: divide master clock, 0: bypass a slave clock
      logic ratio_b;  // 1: second (larger) master ratio
      logic src_ext;  // slave source: 1 external, 0 serial input
   } bclk_cfg_t;

   localparam int unsigned SYS_MODE_OFF = 0;
endpackage

// File: rtl/aclk_sys_tap.sv
`timescale 1ns/1ps
module aclk_sys_tap #(
   parameter int unsigned CNT_W  = 2,
   parameter int unsigned MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   output logic [MODE_W-1:0] mode_act_o,
   output logic              tc_o,
   output logic              sys_clk_o
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("aclk_sys_tap: CNT_W must be at least 1");
      end
      if ((1 << MODE_W) < CNT_W + 2) begin : g_bad_mode
         $error("aclk_sys_tap: MODE_W too narrow for CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   taps;

   assign tc_o = &cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         mode_act_o <= MODE_W'(aclk_pkg::SYS_MODE_OFF);
      end else begin
         cnt <= cnt + 1'b1;
         if (tc_o) mode_act_o <= mode_i;
      end
   end

   // tap 0 is the undivided clock, tap k is the clock divided by 2^k
   assign taps[0] = clk;
   generate
      for (genvar k = 1; k <= CNT_W; k++) begin : g_tap
         assign taps[k] = cnt[k-1];
      end
   endgenerate

   always_comb begin
      sys_clk_o = 1'b0;
      for (int k = 0; k <= CNT_W; k++) begin
         if (mode_act_o == MODE_W'(k + 1)) sys_clk_o = taps[k];
      end
   end
endmodule

// File: rtl/aclk_bclk_gen.sv
`timescale 1ns/1ps
module aclk_bclk_gen #(
   parameter int unsigned DIV_A      = 4,
   parameter int unsigned DIV_B      = 6,
   parameter int unsigned HALF_BCLKS = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  aclk_pkg::bclk_cfg_t cfg_i,
   output aclk_pkg::bclk_cfg_t cfg_act_o,
   output logic               tc_o,
   output logic               bclk_o,
   output logic               ws_o
);
   localparam int unsigned MAX_DIV = (DIV_A > DIV_B) ? DIV_A : DIV_B;
   localparam int unsigned PH_W    = $clog2(MAX_DIV);
   localparam int unsigned BIT_W   = $clog2(2 * HALF_BCLKS);
   localparam logic [PH_W-1:0] HALF_A = PH_W'(DIV_A / 2);
   localparam logic [PH_W-1:0] HALF_B = PH_W'(DIV_B / 2);

   generate
      if (DIV_A < 2 || DIV_B < 2 || (DIV_A % 2) != 0 || (DIV_B % 2) != 0) begin : g_bad_div
         $error("aclk_bclk_gen: dividers must be even and at least 2");
      end
      if ((1 << BIT_W) != 2 * HALF_BCLKS) begin : g_bad_half
         $error("aclk_bclk_gen: HALF_BCLKS must be a power of two");
      end
   endgenerate

   logic [PH_W-1:0]  ph, ph_nxt, half_cur, half_nxt;
   logic [BIT_W-1:0] bit_cnt, bit_nxt;

   assign half_cur = cfg_act_o.ratio_b ? HALF_B : HALF_A;
   assign tc_o     = (ph == (half_cur << 1) - 1'b1);
   assign ph_nxt   = tc_o ? '0 : ph + 1'b1;
   assign half_nxt = tc_o ? (cfg_i.ratio_b ? HALF_B : HALF_A) : half_cur;
   assign bit_nxt  = tc_o ? bit_cnt + 1'b1 : bit_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= '0;
         bit_cnt   <= '0;
         bclk_o    <= 1'b0;
         ws_o      <= 1'b0;
         cfg_act_o <= '{master: 1'b1, ratio_b: 1'b0, src_ext: 1'b0};
      end else begin
         ph      <= ph_nxt;
         bit_cnt <= bit_nxt;
         bclk_o  <= (ph_nxt >= half_nxt);
         ws_o    <= bit_nxt[BIT_W-1];
         if (tc_o) cfg_act_o <= cfg_i;
      end
   end
endmodule

// File: rtl/aclk_bclk_route.sv
`timescale 1ns/1ps
module aclk_bclk_route #(
   parameter int unsigned N_OUT = 2
) (
   input  aclk_pkg::bclk_cfg_t cfg_i,
   input  logic               gen_bclk_i,
   input  logic               gen_ws_i,
   input  logic               ser_bclk_i,
   input  logic               ext_bclk_i,
   output logic [N_OUT-1:0]   bclk_o,
   output logic               ws_o
);
   generate
      if (N_OUT < 1) begin : g_bad_out
         $error("aclk_bclk_route: N_OUT must be at least 1");
      end
   endgenerate

   logic sel;
   assign sel  = cfg_i.master ? gen_bclk_i : (cfg_i.src_ext ? ext_bclk_i : ser_bclk_i);
   assign ws_o = cfg_i.master & gen_ws_i;

   generate
      for (genvar i = 0; i < N_OUT; i++) begin : g_copy
         assign bclk_o[i] = sel;
      end
   endgenerate
endmodule

// File: rtl/audio_clk_sel.sv
`timescale 1ns/1ps
module audio_clk_sel #(
   parameter int unsigned SYS_CNT_W  = 2,
   parameter int unsigned DIV_A      = 4,
   parameter int unsigned DIV_B      = 6,
   parameter int unsigned HALF_BCLKS = 32
) (
   input  logic       proc_clk,
   input  logic       proc_rst_n,
   input  logic       mclk,
   input  logic       mclk_rst_n,
   input  logic [1:0] sys_mode_i,
   input  logic       master_i,
   input  logic       ratio384_i,
   input  logic       slv_src_i,
   input  logic       ser_bclk_i,
   input  logic       ext_bclk_i,
   output logic       sys_clk_o,
   output logic       bclk_o,
   output logic       bclk2_o,
   output logic       ws_o
);
   localparam int unsigned MODE_W = 2;
   localparam int unsigned N_OUT  = 2;

   generate
      if (SYS_CNT_W > 2) begin : g_bad_sys
         $error("audio_clk_sel: a 2-bit mode port selects at most divide by 4");
      end
   endgenerate

   logic [MODE_W-1:0]    sys_mode_act;
   logic                 sys_tc;
   aclk_pkg::bclk_cfg_t  bclk_cfg_req, bclk_cfg_act;
   logic                 bclk_tc, gen_bclk, gen_ws;
   logic [N_OUT-1:0]     bclk_vec;

   assign bclk_cfg_req = '{master: master_i, ratio_b: ratio384_i, src_ext: slv_src_i};

   aclk_sys_tap #(.CNT_W(SYS_CNT_W), .MODE_W(MODE_W)) u_sys (
      .clk(proc_clk), .rst_n(proc_rst_n), .mode_i(sys_mode_i),
      .mode_act_o(sys_mode_act), .tc_o(sys_tc), .sys_clk_o(sys_clk_o)
   );

   aclk_bclk_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .HALF_BCLKS(HALF_BCLKS)) u_gen (
      .clk(mclk), .rst_n(mclk_rst_n), .cfg_i(bclk_cfg_req), .cfg_act_o(bclk_cfg_act),
      .tc_o(bclk_tc), .bclk_o(gen_bclk), .ws_o(gen_ws)
   );

   aclk_bclk_route #(.N_OUT(N_OUT)) u_route (
      .cfg_i(bclk_cfg_act), .gen_bclk_i(gen_bclk), .gen_ws_i(gen_ws),
      .ser_bclk_i(ser_bclk_i), .ext_bclk_i(ext_bclk_i), .bclk_o(bclk_vec), .ws_o(ws_o)
   );

   assign bclk_o  = bclk_vec[0];
   assign bclk2_o = bclk_vec[N_OUT-1];
endmodule

// File: rtl/aclk_chk.sv
`timescale 1ns/1ps
module aclk_chk #(
   parameter int unsigned MODE_W   = 2,
   parameter int unsigned MAX_HALF = 3
) (
   input logic               proc_clk,
   input logic               proc_rst_n,
   input logic               mclk,
   input logic               mclk_rst_n,
   input logic [MODE_W-1:0]  sys_mode_act,
   input logic               sys_tc,
   input logic               sys_clk_o,
   input aclk_pkg::bclk_cfg_t bclk_cfg_act,
   input logic               bclk_tc,
   input logic               bclk_o,
   input logic               ws_o
);
   logic [7:0] hi_run;
   always_ff @(posedge mclk or negedge mclk_rst_n) begin
      if (!mclk_rst_n) hi_run <= '0;
      else if (bclk_o && bclk_cfg_act.master) hi_run <= hi_run + 1'b1;
      else hi_run <= '0;
   end

   a_r1_off_low: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
      (sys_mode_act == '0) |-> !sys_clk_o);

   a_r3_div2_toggle: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
      (sys_mode_act == MODE_W'(2) && $past(sys_mode_act) == MODE_W'(2)) |-> (sys_clk_o != $past(sys_clk_o)));

   a_r4_mode_at_tc: assert property (@(posedge proc_clk) disable iff (!proc_rst_n)
      !$stable(sys_mode_act) |-> $past(sys_tc));

   a_r10_cfg_at_tc: assert property (@(posedge mclk) disable iff (!mclk_rst_n)
      !$stable(bclk_cfg_act) |-> $past(bclk_tc));

   a_r7_ws_on_fall: assert property (@(posedge mclk) disable iff (!mclk_rst_n)
      (!$stable(ws_o) && bclk_cfg_act.master && $past(bclk_cfg_act.master)) |-> (!bclk_o && $past(bclk_o)));

   a_r6_high_bounded: assert property (@(posedge mclk) disable iff (!mclk_rst_n)
      hi_run <= 8'(MAX_HALF));
endmodule

bind audio_clk_sel aclk_chk #(.MODE_W(2), .MAX_HALF(3)) i_chk (
   .proc_clk(proc_clk), .proc_rst_n(proc_rst_n), .mclk(mclk), .mclk_rst_n(mclk_rst_n),
   .sys_mode_act(sys_mode_act), .sys_tc(sys_tc), .sys_clk_o(sys_clk_o),
   .bclk_cfg_act(bclk_cfg_act), .bclk_tc(bclk_tc), .bclk_o(bclk_o), .ws_o(ws_o)
);

// File: tb/test_audio_clk_sel.sv
`timescale 1ns/1ps
module test_audio_clk_sel;
   logic proc_clk = 0, mclk = 0, ser_bclk = 0, ext_bclk = 0;
   logic proc_rst_n = 0, mclk_rst_n = 0;
   logic [1:0] sys_mode = 0;
   logic master = 1, ratio384 = 0, slv_src = 0;
   logic sys_clk, bclk, bclk2, ws;
   int total = 0, bad = 0;
   bit done = 0;

   always #2 proc_clk = ~proc_clk;   // 250 MHz
   always #5 mclk = ~mclk;
   always #12 ser_bclk = ~ser_bclk;
   always #7 ext_bclk = ~ext_bclk;

   audio_clk_sel i_audio_clk_sel (
      .proc_clk(proc_clk), .proc_rst_n(proc_rst_n), .mclk(mclk), .mclk_rst_n(mclk_rst_n),
      .sys_mode_i(sys_mode), .master_i(master), .ratio384_i(ratio384), .slv_src_i(slv_src),
      .ser_bclk_i(ser_bclk), .ext_bclk_i(ext_bclk),
      .sys_clk_o(sys_clk), .bclk_o(bclk), .bclk2_o(bclk2), .ws_o(ws)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_sys_per(input int m);
      return 1 << (m - 1);
   endfunction
   function automatic int exp_bclk_per(input bit r);
      return r ? 6 : 4;
   endfunction

   task automatic meas_sys(output int per, output int hi);
      logic prev, v;
      prev = 1; per = 0; hi = 0;
      for (int i = 0; i < 64; i++) begin
         @(negedge proc_clk); v = sys_clk;
         if (!prev && v) break;
         prev = v;
      end
      per = 1; hi = 1; prev = 1;
      for (int i = 0; i < 64; i++) begin
         @(negedge proc_clk); v = sys_clk;
         if (!prev && v) break;
         per++; hi += int'(v); prev = v;
      end
   endtask

   task automatic meas_bclk(output int per, output int hi, output int mism);
      logic prev, v;
      prev = 1; mism = 0;
      for (int i = 0; i < 64; i++) begin
         @(negedge mclk); v = bclk; if (bclk2 !== bclk) mism++;
         if (!prev && v) break;
         prev = v;
      end
      per = 1; hi = 1; prev = 1;
      for (int i = 0; i < 64; i++) begin
         @(negedge mclk); v = bclk; if (bclk2 !== bclk) mism++;
         if (!prev && v) break;
         per++; hi += int'(v); prev = v;
      end
   endtask

   task automatic meas_ws(output int per, output int hi, output int badedge);
      logic prev, v, pb;
      prev = 1; badedge = 0; pb = bclk;
      for (int i = 0; i < 1000; i++) begin
         @(negedge mclk); v = ws;
         if (!prev && v) break;
         prev = v; pb = bclk;
      end
      if (!(pb && !bclk)) badedge++;
      per = 1; hi = 1; prev = 1; pb = bclk;
      for (int i = 0; i < 1000; i++) begin
         @(negedge mclk); v = ws;
         if (v != prev && !(pb && !bclk)) badedge++;
         if (!prev && v) break;
         per++; hi += int'(v); prev = v; pb = bclk;
      end
   endtask

   task automatic check_sys(input int m, input string tag);
      int per, hi;
      if (m == 0) begin
         int highs = 0;
         for (int i = 0; i < 8; i++) begin
            @(negedge proc_clk); highs += int'(sys_clk);
            @(posedge proc_clk); #1; highs += int'(sys_clk);
         end
         chk(highs == 0, {"R1 ", tag}, highs, 0);
      end else if (m == 1) begin
         int errs = 0;
         for (int i = 0; i < 8; i++) begin
            @(negedge proc_clk); #0.5; if (sys_clk !== 1'b0) errs++;
            @(posedge proc_clk); #1;   if (sys_clk !== 1'b1) errs++;
         end
         chk(errs == 0, {"R2 ", tag}, errs, 0);
      end else begin
         meas_sys(per, hi);
         chk(per == exp_sys_per(m), {"R3 period ", tag}, per, exp_sys_per(m));
         chk(hi == exp_sys_per(m) / 2, {"R3 high ", tag}, hi, exp_sys_per(m) / 2);
      end
   endtask

   task automatic check_bclk(input bit ms, input bit r, input bit src, input string tag);
      int per, hi, mm, errs;
      if (ms) begin
         meas_bclk(per, hi, mm);
         chk(per == exp_bclk_per(r), {r ? "R6 period " : "R5 period ", tag}, per, exp_bclk_per(r));
         chk(hi == exp_bclk_per(r) / 2, {r ? "R6 high " : "R5 high ", tag}, hi, exp_bclk_per(r) / 2);
         chk(mm == 0, {"R9 master ", tag}, mm, 0);
      end else begin
         errs = 0; mm = 0;
         for (int i = 0; i < 24; i++) begin
            repeat ($urandom % 3 + 1) @(negedge mclk);
            #0.3;
            if (bclk !== (src ? ext_bclk : ser_bclk)) errs++;
            if (bclk2 !== bclk) mm++;
            if (ws !== 1'b0) errs++;
         end
         chk(errs == 0, {"R8 slave ", tag}, errs, 0);
         chk(mm == 0, {"R9 slave ", tag}, mm, 0);
      end
   endtask

   initial begin
      int per, hi, be;
      logic v, prev;
      int exp_seq[7];
      void'($urandom(32'd1234));

      // R11: reset state, then release with a div2 request pending
      sys_mode = 2'd2;
      repeat (3) @(negedge proc_clk);
      chk(sys_clk == 0 && bclk == 0 && bclk2 == 0 && ws == 0, "R11 outputs low in reset",
          {sys_clk, bclk, bclk2, ws}, 0);
      @(negedge mclk); mclk_rst_n = 1;
      @(negedge proc_clk); proc_rst_n = 1;
      be = 0;
      for (int i = 0; i < 4; i++) begin @(negedge proc_clk); be += int'(sys_clk); end
      chk(be == 0, "R11 sys off first 4 cycles", be, 0);
      @(negedge proc_clk);
      chk(sys_clk == 1, "R11 div2 starts after first wrap", sys_clk, 1);
      check_bclk(1, 0, 0, "after reset 256");

      // R4: mid-period change from div4 to div2
      @(negedge proc_clk); sys_mode = 2'd3;
      repeat (10) @(negedge proc_clk);
      prev = 0;
      for (int i = 0; i < 64; i++) begin
         @(negedge proc_clk); v = sys_clk;
         if (prev && !v) break;
         prev = v;
      end
      sys_mode = 2'd2;
      exp_seq = '{0, 1, 1, 0, 1, 0, 1};
      be = 0;
      for (int i = 0; i < 7; i++) begin
         @(negedge proc_clk); if (sys_clk !== exp_seq[i][0]) be++;
      end
      chk(be == 0, "R4 change waits for wrap", be, 0);

      // R10: 256 -> 384 just after a bit-clock rise
      prev = 1;
      for (int i = 0; i < 64; i++) begin
         @(negedge mclk); v = bclk;
         if (!prev && v) break;
         prev = v;
      end
      ratio384 = 1;
      exp_seq = '{1, 0, 0, 0, 1, 1, 1};
      be = 0;
      for (int i = 0; i < 7; i++) begin
         @(negedge mclk); if (bclk !== exp_seq[i][0]) be++;
      end
      chk(be == 0, "R10 period completes at old length", be, 0);

      // R7: word select in both ratios
      for (int r = 0; r < 2; r++) begin
         @(negedge mclk); ratio384 = r[0];
         repeat (14) @(negedge mclk);
         meas_ws(per, hi, be);
         chk(per == 64 * exp_bclk_per(r[0]), "R7 ws period", per, 64 * exp_bclk_per(r[0]));
         chk(hi == 32 * exp_bclk_per(r[0]), "R7 ws high", hi, 32 * exp_bclk_per(r[0]));
         chk(be == 0, "R7 ws moves on bclk fall", be, 0);
      end

      // directed corners: off, div1, both slave sources
      @(negedge proc_clk); sys_mode = 2'd0; repeat (10) @(negedge proc_clk);
      check_sys(0, "directed off");
      @(negedge proc_clk); sys_mode = 2'd1; repeat (10) @(negedge proc_clk);
      check_sys(1, "directed div1");
      for (int s = 0; s < 2; s++) begin
         @(negedge mclk); master = 0; slv_src = s[0];
         repeat (14) @(negedge mclk);
         check_bclk(0, ratio384, s[0], "directed slave");
      end

      // constrained random configurations
      for (int it = 0; it < 14; it++) begin
         int m; bit ms, r, s;
         m = int'($urandom % 4); ms = 1'($urandom); r = 1'($urandom); s = 1'($urandom);
         @(negedge proc_clk); sys_mode = m[1:0];
         @(negedge mclk); master = ms; ratio384 = r; slv_src = s;
         repeat (10) @(negedge proc_clk);
         repeat (14) @(negedge mclk);
         check_sys(m, "random");
         check_bclk(ms, r, s, "random");
      end

      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge proc_clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule